// File: doc/BRIEF.md
# Dual-Word Parallel Synthesiser Programming Port

This block is the configuration front end of a frequency synthesiser loop. A single 16-bit parallel bus, one address bit and one strobe feed two word groups. The divider group holds the prescaler swallow count, the main divide count and the phase detector gain select. The reference group holds the reference divide count, the phase detector enable and the detector sense. Software programs both groups once; after that a frequency change needs only a new divider word, because the reference group keeps its value across writes to the other group.

The strobe has two jobs. While it is high, the group picked by the address follows the bus, and the block raises a hold output that keeps the downstream counters in reset and keeps the charge pump off. When the strobe falls, the captured word is frozen and both groups are copied into the active registers that drive the counters. From then on the counters run and the pump is enabled. All inputs are brought into the system clock domain through synchroniser chains. Reset puts every register at all ones. This matches a bus whose inputs are left open and float high.

Top module: `dual_word_prog_if`

## Requirements
- R1: After reset every output field is all ones, the counter hold output is 1 and the pump enable output is 0.
- R2: A write with address 1 loads the divider group: swallow count from bus bits 2:0, main count from bits 13:3 and gain select from bits 15:14.
- R3: A write with address 0 loads the reference group: reference divide count from bus bits 9:0, detector enable from bit 10 and detector sense from bit 12. Bits 11, 13, 14 and 15 have no effect on any output.
- R4: While the strobe is high, no output field changes.
- R5: The word that takes effect is the last bus value present before the strobe falls. Earlier bus values seen during the same strobe pulse are discarded.
- R6: A write to one group leaves every output of the other group unchanged.
- R7: Within three clock cycles of the strobe rising, the counter hold output is 1 and the pump enable output is 0. The hold output stays 1 as long as the strobe stays high.
- R8: While the strobe is low, the counter hold output is 0 and the pump enable output equals the active detector enable bit.
- R9: Bus and address changes while the strobe is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busIn | input | 16 | Parallel programming data |
| addrIn | input | 1 | Group select: 1 for the divider group, 0 for the reference group |
| strobeIn | input | 1 | Level-sensitive capture enable and counter hold request |
| swallowCnt | output | 3 | Active prescaler swallow count |
| mainCnt | output | 11 | Active main divide count |
| pumpGain | output | 2 | Active phase detector gain select |
| refDiv | output | 10 | Active reference divide count |
| detectorEnable | output | 1 | Active phase detector enable |
| detectorSense | output | 1 | Active phase detector sense |
| counterHold | output | 1 | Holds the dividers in reset and the pump off |
| pumpOn | output | 1 | Charge pump enable |

## Verification
The case that is hardest to reach from the ports is a strobe pulse in which the bus changes several times before the final value settles. The test must show that only that last word is committed and that no intermediate value ever reaches the outputs. Every write in the bench first presents a random noise word while the strobe is high, then switches to the intended word before releasing the strobe. During the noise phase the outputs are checked against the previously committed state. Separate phases also drive random bus and address activity with the strobe low, and alternate single-group writes to show that the untouched group holds its value.

// File: rtl/dwpi_pkg.sv
package dwpi_pkg;
  localparam int BUS_W     = 16;
  localparam int SWALLOW_W = 3;
  localparam int MAIN_W    = 11;
  localparam int GAIN_W    = 2;
  localparam int REFDIV_W  = 10;
  localparam int PD_EN_BIT = 10;
  localparam int SENSE_BIT = 12;
  localparam int MAIN_LSB  = SWALLOW_W;
  localparam int GAIN_LSB  = SWALLOW_W + MAIN_W;

  typedef struct packed {
    logic captureRf;
    logic captureRef;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/dwpi_sync.sv
module dwpi_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= dIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/dwpi_ctrl.sv
module dwpi_ctrl
  import dwpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrIn,
  input  logic         strobeIn,
  output ctrlStrobes_t strobes,
  output logic         holdOut
);
  logic [1:0] ctlSync;
  logic       addrSync;
  logic       strbSync;
  logic       strbPrev;

  dwpi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) ctlSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({addrIn, strobeIn}),
    .qOut (ctlSync)
  );

  assign addrSync = ctlSync[1];
  assign strbSync = ctlSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbPrev <= 1'b1;
    else       strbPrev <= strbSync;
  end

  always_comb begin
    strobes.captureRf  = strbSync & addrSync;
    strobes.captureRef = strbSync & ~addrSync;
    strobes.commit     = strbPrev & ~strbSync;
  end

  assign holdOut = strbSync;
endmodule

// File: rtl/dwpi_datapath.sv
module dwpi_datapath
  import dwpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_W-1:0]     busIn,
  input  ctrlStrobes_t         strobes,
  input  logic                 holdIn,
  output logic [SWALLOW_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0]    mainCnt,
  output logic [GAIN_W-1:0]    pumpGain,
  output logic [REFDIV_W-1:0]  refDiv,
  output logic                 detectorEnable,
  output logic                 detectorSense,
  output logic                 pumpOn
);
  logic [BUS_W-1:0] busSync;
  logic [BUS_W-1:0] rfBuf, refBuf;
  logic [BUS_W-1:0] rfAct, refAct;

  dwpi_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) busSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (busIn),
    .qOut (busSync)
  );

  // Transparent buffers: follow the bus while their group is selected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfBuf  <= '1;
      refBuf <= '1;
    end else begin
      if (strobes.captureRf)  rfBuf  <= busSync;
      if (strobes.captureRef) refBuf <= busSync;
    end
  end

  // Active registers seen by the counters, loaded on strobe release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfAct  <= '1;
      refAct <= '1;
    end else if (strobes.commit) begin
      rfAct  <= rfBuf;
      refAct <= refBuf;
    end
  end

  assign swallowCnt     = rfAct[SWALLOW_W-1:0];
  assign mainCnt        = rfAct[MAIN_LSB +: MAIN_W];
  assign pumpGain       = rfAct[GAIN_LSB +: GAIN_W];
  assign refDiv         = refAct[REFDIV_W-1:0];
  assign detectorEnable = refAct[PD_EN_BIT];
  assign detectorSense  = refAct[SENSE_BIT];
  assign pumpOn         = ~holdIn & refAct[PD_EN_BIT];
endmodule

// File: rtl/dual_word_prog_if.sv
module dual_word_prog_if
  import dwpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_W-1:0]     busIn,
  input  logic                 addrIn,
  input  logic                 strobeIn,
  output logic [SWALLOW_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0]    mainCnt,
  output logic [GAIN_W-1:0]    pumpGain,
  output logic [REFDIV_W-1:0]  refDiv,
  output logic                 detectorEnable,
  output logic                 detectorSense,
  output logic                 counterHold,
  output logic                 pumpOn
);
  ctrlStrobes_t ctrlStrobes;

  dwpi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .strobeIn (strobeIn),
    .strobes  (ctrlStrobes),
    .holdOut  (counterHold)
  );

  dwpi_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .busIn          (busIn),
    .strobes        (ctrlStrobes),
    .holdIn         (counterHold),
    .swallowCnt     (swallowCnt),
    .mainCnt        (mainCnt),
    .pumpGain       (pumpGain),
    .refDiv         (refDiv),
    .detectorEnable (detectorEnable),
    .detectorSense  (detectorSense),
    .pumpOn         (pumpOn)
  );
endmodule

// File: rtl/dwpi_checker.sv
module dwpi_checker
  import dwpi_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input ctrlStrobes_t         strobes,
  input logic [SWALLOW_W-1:0] swallowCnt,
  input logic [MAIN_W-1:0]    mainCnt,
  input logic [GAIN_W-1:0]    pumpGain,
  input logic [REFDIV_W-1:0]  refDiv,
  input logic                 detectorEnable,
  input logic                 detectorSense,
  input logic                 counterHold,
  input logic                 pumpOn
);
  logic [SWALLOW_W+MAIN_W+GAIN_W+REFDIV_W+1:0] allFields;
  assign allFields = {swallowCnt, mainCnt, pumpGain, refDiv, detectorEnable, detectorSense};

  // R1
  reset_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&allFields && counterHold && !pumpOn));

  // R4
  frozen_while_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterHold |=> $stable(allFields));

  // R9
  commit_only_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(allFields) |-> ($past(counterHold, 2) && !$past(counterHold)));

  // R7
  hold_blocks_pump_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterHold |-> !pumpOn);

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.captureRf, strobes.captureRef, strobes.commit}));
endmodule

bind dual_word_prog_if dwpi_checker chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .strobes        (ctrlStrobes),
  .swallowCnt     (swallowCnt),
  .mainCnt        (mainCnt),
  .pumpGain       (pumpGain),
  .refDiv         (refDiv),
  .detectorEnable (detectorEnable),
  .detectorSense  (detectorSense),
  .counterHold    (counterHold),
  .pumpOn         (pumpOn)
);

// File: tb/dual_word_prog_if_tb_top.sv
module dual_word_prog_if_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busIn = 16'hFFFF;
  logic        addrIn = 1'b1;
  logic        strobeIn = 1'b1;
  logic [2:0]  swallowCnt;
  logic [10:0] mainCnt;
  logic [1:0]  pumpGain;
  logic [9:0]  refDiv;
  logic        detectorEnable, detectorSense, counterHold, pumpOn;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [15:0] rfModel = 16'hFFFF;
  logic [15:0] refModel = 16'hFFFF;

  always #5 clk = ~clk;

  dual_word_prog_if dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .addrIn(addrIn), .strobeIn(strobeIn),
    .swallowCnt(swallowCnt), .mainCnt(mainCnt), .pumpGain(pumpGain), .refDiv(refDiv),
    .detectorEnable(detectorEnable), .detectorSense(detectorSense),
    .counterHold(counterHold), .pumpOn(pumpOn)
  );

  function automatic logic [31:0] expRf(input logic [15:0] w);
    return {11'd0, w[2:0], w[13:3], w[15:14]};
  endfunction

  function automatic logic [31:0] expRef(input logic [15:0] w);
    return {20'd0, w[9:0], w[10], w[12]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkGroups(input string req);
    chk(req, {11'd0, swallowCnt, mainCnt, pumpGain}, expRf(rfModel));
    chk(req, {20'd0, refDiv, detectorEnable, detectorSense}, expRef(refModel));
  endtask

  task automatic checkRunning(input string req);
    checkGroups(req);
    chk({req, " R8"}, {counterHold, pumpOn}, {1'b0, refModel[10]});
  endtask

  // Write one word: noise first while strobe is high, then the real word.
  task automatic writeWord(input logic addr, input logic [15:0] data, input logic [15:0] noise,
                           input string req);
    @(negedge clk);
    strobeIn = 1'b1; addrIn = addr; busIn = noise;
    repeat (3) @(negedge clk);
    chk("R7 hold", {counterHold, pumpOn}, 2'b10);
    checkGroups("R4 frozen during noise");
    busIn = data;
    repeat (3) @(negedge clk);
    checkGroups("R4 frozen before release");
    strobeIn = 1'b0;
    if (addr) rfModel = data; else refModel = data;
    repeat (5) @(negedge clk);
    checkRunning(req);
  endtask

  initial begin : main
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkGroups("R1 reset fields");
    chk("R1 reset hold/pump", {counterHold, pumpOn}, 2'b10);

    // Directed cases
    writeWord(1'b1, 16'h0000, 16'hFFFF, "R2 rf all zeros");
    writeWord(1'b0, 16'hEC00 & 16'hFBFF | 16'h0155, 16'h1234, "R3 ref ignored bits set");
    writeWord(1'b0, 16'h0000, 16'hFFFF, "R3 ref zeros");
    writeWord(1'b1, 16'hFFFF, 16'h0000, "R2 rf all ones");
    writeWord(1'b1, 16'h4A5B, 16'hB5A4, "R5 last bus value wins");
    writeWord(1'b0, 16'h17FF, 16'h0000, "R8 detector enabled");
    writeWord(1'b1, 16'h8001, 16'h7FFE, "R6 ref kept on rf write");
    writeWord(1'b0, 16'h0003, 16'hFFFC, "R6 rf kept on ref write");

    // R9: activity with strobe low
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      busIn = 16'($urandom);
      addrIn = 1'($urandom);
      repeat (2) @(negedge clk);
      checkRunning("R9 ignored while strobe low");
    end

    // Random writes
    for (int i = 0; i < 40; i++) begin
      writeWord(1'($urandom), 16'($urandom), 16'($urandom), "R2 R3 R6 random write");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule